// File: doc/BRIEF.md
# Dual-Mode PI Output-Voltage Regulator

This block closes the slow outer loop of a power-factor correction stage. Each accepted output-voltage sample triggers one proportional-integral update. The update produces a saturated command that scales the current-loop reference further downstream. Samples arrive on a valid/ready stream. A sideband flag travels with each beat and marks the sample taken at a line zero crossing. That sample is latched and held, and it becomes the feedback value in steady state. Because the latched value sits at the average of the double-line-frequency ripple, the ripple stays out of the command.

The block chooses its mode for every update from the instantaneous error, which is the reference minus the live sample.
- **Quiet mode:** while that error stays under a programmable threshold, the block regulates on the held zero-crossing sample with a gentle gain pair.
- **Recovery mode:** once the error reaches the threshold, the block uses the live sample and a second, stronger gain pair, so that it can pull the bus back after a load step.

Both modes share one integrator, so a change of mode does not cause a step in the command. The integrator and the command are clamped to programmable limits. Integration freezes while the previous command sat on a limit and the new increment would push further into it. All arithmetic is two's-complement. Each gain is a signed integer whose unit value is 2^FRAC_BITS, and each scaled product is truncated toward zero.

The result leaves on a one-deep valid/ready output register. A new sample is accepted only when that register is empty or is being drained in the same cycle. If the consumer holds ready low, the result stays unchanged and the block refuses further samples, so no update is ever lost or repeated.

Top module: `vloop_dual_pi`

## Requirements
- R1: During and right after reset, `smp_ready` is 1 and `out_valid` is 0. The integrator is zero, the saturation history is clear, and no zero-crossing sample is held.
- R2: A beat accepted with `smp_zc`=1 latches its sample as the held feedback value, and that same beat already uses it. Later quiet-mode beats use the held value until the next marked beat.
- R3: Until the first marked beat after reset, quiet mode uses the live sample as feedback.
- R4: The instantaneous error is `vref - smp_data`, computed signed. If it is greater than or equal to `err_thresh` (signed), the update is in recovery mode: error = instantaneous error, gains `kp_fast`/`ki_fast`. Otherwise it is in quiet mode: error = `vref` minus the feedback value, gains `kp_slow`/`ki_slow`.
- R5: For each update, P = trunc(kp·e / 2^FRAC_BITS) and I = trunc(ki·e / 2^FRAC_BITS). I is added to the single integrator, which is shared by both modes.
- R6: The command is the new integrator plus P, clamped to [`out_min`, `out_max`].
- R7: The integrator keeps its value when the previous command was at or above `out_max` and I > 0, or at or below `out_min` and I < 0.
- R8: Otherwise the integrator becomes (integrator + I) clamped to [`out_min`, `out_max`].
- R9: Each accepted sample yields exactly one output beat. It has `out_valid`=1 in the cycle after acceptance.
- R10: While `out_valid`=1 and `out_ready`=0, `out_data` stays stable and `smp_ready` is 0. Samples offered meanwhile are not consumed.
- R11: Scaled products truncate toward zero for negative values. For example, -3·6143/4096 gives -4 and -3·1365/4096 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Output-voltage sample valid |
| smp_ready | output | 1 | Block can take a sample |
| smp_data | input | DATA_W | Signed output-voltage sample |
| smp_zc | input | 1 | Beat is the zero-crossing sample |
| vref | input | DATA_W | Signed voltage reference |
| err_thresh | input | DATA_W | Signed recovery-mode threshold |
| kp_slow | input | GAIN_W | Quiet-mode proportional gain |
| ki_slow | input | GAIN_W | Quiet-mode integral gain |
| kp_fast | input | GAIN_W | Recovery-mode proportional gain |
| ki_fast | input | GAIN_W | Recovery-mode integral gain |
| out_min | input | OUT_W | Lower command / integrator limit |
| out_max | input | OUT_W | Upper command / integrator limit |
| out_valid | output | 1 | Command valid |
| out_ready | input | 1 | Consumer takes the command |
| out_data | output | OUT_W | Signed saturated command |

## Verification
Several sample sequences exercise the feedback choice:
- An unmarked sample before any zero crossing shows whether the live value is used or a stale held register.
- A marked sample followed by drifting live samples shows whether the held value is used.
- Samples placed exactly at the threshold and one code beside it pin the direction of the mode comparison.
- Runs that switch modes in both directions, with integral-only gains, show whether the integrator is shared or restarts.

A small negative error with awkward gains separates truncation toward zero from floor rounding. A strong proportional term that drives the command into its limit, followed by an error reversal, separates a frozen integrator from a wound-up one. A stalled consumer shows that results are held and that no sample is consumed twice.

// File: rtl/vloop_pkg.sv
`timescale 1ns/1ps
package vloop_pkg;
  typedef enum logic {
    LOOP_QUIET   = 1'b0,
    LOOP_RECOVER = 1'b1
  } loop_mode_e;

  localparam int GAIN_SEL_P = 0;
  localparam int GAIN_SEL_I = 1;
  localparam int GAIN_COUNT = 2;
endpackage

// File: rtl/vloop_err_sel.sv
`timescale 1ns/1ps
module vloop_err_sel
  import vloop_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ERR_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic                     zc_mark,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic signed [DATA_W-1:0] vref,
  input  logic signed [DATA_W-1:0] thresh,
  output logic signed [ERR_W-1:0]  err,
  output loop_mode_e               mode
);
  logic signed [DATA_W-1:0] held_q;
  logic                     held_vld_q;
  logic signed [DATA_W-1:0] fb;
  logic signed [ERR_W-1:0]  e_live;
  logic signed [ERR_W-1:0]  e_hold;

  always_comb begin
    if (zc_mark || !held_vld_q) fb = smp_data;
    else                        fb = held_q;
    e_live = ERR_W'(vref) - ERR_W'(smp_data);
    e_hold = ERR_W'(vref) - ERR_W'(fb);
    mode   = (e_live >= ERR_W'(thresh)) ? LOOP_RECOVER : LOOP_QUIET;
    err    = (mode == LOOP_RECOVER) ? e_live : e_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q     <= '0;
      held_vld_q <= 1'b0;
    end else if (upd && zc_mark) begin
      held_q     <= smp_data;
      held_vld_q <= 1'b1;
    end
  end

  // R2
  zc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && zc_mark) |=> (held_vld_q && held_q == $past(smp_data)));
  // R2
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(held_vld_q));
endmodule

// File: rtl/vloop_scaled_mul.sv
`timescale 1ns/1ps
module vloop_scaled_mul #(
  parameter int A_W  = 17,
  parameter int K_W  = 16,
  parameter int FRAC = 12,
  localparam int PW  = A_W + K_W
) (
  input  logic signed [A_W-1:0] a,
  input  logic signed [K_W-1:0] k,
  output logic signed [PW-1:0]  y
);
  localparam logic signed [PW-1:0] BIAS = PW'((64'sd1 <<< FRAC) - 64'sd1);
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] biased;

  always_comb begin
    prod   = PW'(a) * PW'(k);
    biased = prod[PW-1] ? (prod + BIAS) : prod;
    y      = biased >>> FRAC;
  end
endmodule

// File: rtl/vloop_pi_core.sv
`timescale 1ns/1ps
module vloop_pi_core
  import vloop_pkg::*;
#(
  parameter int ERR_W  = 17,
  parameter int GAIN_W = 16,
  parameter int OUT_W  = 16,
  parameter int FRAC   = 12,
  localparam int PW    = ERR_W + GAIN_W,
  localparam int SW    = ((PW > OUT_W) ? PW : OUT_W) + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic signed [ERR_W-1:0]  err,
  input  loop_mode_e               mode,
  input  logic signed [GAIN_W-1:0] kp_slow,
  input  logic signed [GAIN_W-1:0] ki_slow,
  input  logic signed [GAIN_W-1:0] kp_fast,
  input  logic signed [GAIN_W-1:0] ki_fast,
  input  logic signed [OUT_W-1:0]  lo_lim,
  input  logic signed [OUT_W-1:0]  hi_lim,
  output logic signed [OUT_W-1:0]  u_o
);
  logic signed [GAIN_W-1:0] gsel   [GAIN_COUNT];
  logic signed [PW-1:0]     scaled [GAIN_COUNT];

  assign gsel[GAIN_SEL_P] = (mode == LOOP_RECOVER) ? kp_fast : kp_slow;
  assign gsel[GAIN_SEL_I] = (mode == LOOP_RECOVER) ? ki_fast : ki_slow;

  for (genvar g = 0; g < GAIN_COUNT; g++) begin : g_mul
    vloop_scaled_mul #(.A_W(ERR_W), .K_W(GAIN_W), .FRAC(FRAC)) mul_i (
      .a(err),
      .k(gsel[g]),
      .y(scaled[g])
    );
  end

  function automatic logic signed [OUT_W-1:0] clip(
    input logic signed [SW-1:0]    x,
    input logic signed [OUT_W-1:0] lo,
    input logic signed [OUT_W-1:0] hi
  );
    if (x > SW'(hi))      return hi;
    else if (x < SW'(lo)) return lo;
    else                  return OUT_W'(x);
  endfunction

  logic signed [OUT_W-1:0] acc_q;
  logic                    sat_hi_q, sat_lo_q;
  logic signed [SW-1:0]    p_term, i_term, acc_sum, u_raw;
  logic signed [OUT_W-1:0] acc_n;
  logic                    hold;

  always_comb begin
    p_term  = SW'(scaled[GAIN_SEL_P]);
    i_term  = SW'(scaled[GAIN_SEL_I]);
    acc_sum = SW'(acc_q) + i_term;
    hold    = (sat_hi_q && i_term > 0) || (sat_lo_q && i_term < 0);
    acc_n   = hold ? acc_q : clip(acc_sum, lo_lim, hi_lim);
    u_raw   = SW'(acc_n) + p_term;
    u_o     = clip(u_raw, lo_lim, hi_lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sat_hi_q <= 1'b0;
      sat_lo_q <= 1'b0;
    end else if (upd) begin
      acc_q    <= acc_n;
      sat_hi_q <= (u_raw >= SW'(hi_lim));
      sat_lo_q <= (u_raw <= SW'(lo_lim));
    end
  end

  // R8
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !hold && lo_lim <= hi_lim) |=>
      (acc_q >= $past(lo_lim) && acc_q <= $past(hi_lim)));
  // R7
  windup_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && sat_hi_q && i_term > 0) |=> (acc_q == $past(acc_q)));
endmodule

// File: rtl/vloop_out_reg.sv
`timescale 1ns/1ps
module vloop_out_reg #(
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [OUT_W-1:0] din,
  output logic                    can_load,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/vloop_dual_pi.sv
`timescale 1ns/1ps
module vloop_dual_pi
  import vloop_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GAIN_W    = 16,
  parameter int OUT_W     = 16,
  parameter int FRAC_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  output logic                     smp_ready,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic                     smp_zc,
  input  logic signed [DATA_W-1:0] vref,
  input  logic signed [DATA_W-1:0] err_thresh,
  input  logic signed [GAIN_W-1:0] kp_slow,
  input  logic signed [GAIN_W-1:0] ki_slow,
  input  logic signed [GAIN_W-1:0] kp_fast,
  input  logic signed [GAIN_W-1:0] ki_fast,
  input  logic signed [OUT_W-1:0]  out_min,
  input  logic signed [OUT_W-1:0]  out_max,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int ERR_W = DATA_W + 1;

  logic                    upd;
  logic signed [ERR_W-1:0] err;
  loop_mode_e              mode;
  logic signed [OUT_W-1:0] u_next;

  assign upd = smp_valid && smp_ready;

  vloop_err_sel #(.DATA_W(DATA_W)) err_sel_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .zc_mark  (smp_zc),
    .smp_data (smp_data),
    .vref     (vref),
    .thresh   (err_thresh),
    .err      (err),
    .mode     (mode)
  );

  vloop_pi_core #(
    .ERR_W(ERR_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W), .FRAC(FRAC_BITS)
  ) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd),
    .err     (err),
    .mode    (mode),
    .kp_slow (kp_slow),
    .ki_slow (ki_slow),
    .kp_fast (kp_fast),
    .ki_fast (ki_fast),
    .lo_lim  (out_min),
    .hi_lim  (out_max),
    .u_o     (u_next)
  );

  vloop_out_reg #(.OUT_W(OUT_W)) oreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (upd),
    .din       (u_next),
    .can_load  (smp_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> out_valid);
  // R6
  out_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && out_min <= out_max) |=>
      (out_data >= $past(out_min) && out_data <= $past(out_max)));
endmodule

// File: tb/vloop_dual_pi_tb.sv
`timescale 1ns/1ps
module vloop_dual_pi_tb_top;
  localparam int DW = 16;
  localparam int FB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_ready, smp_zc = 1'b0;
  logic signed [DW-1:0] smp_data = '0, vref = '0, err_thresh = '0;
  logic signed [DW-1:0] kp_slow = '0, ki_slow = '0, kp_fast = '0, ki_fast = '0;
  logic signed [DW-1:0] out_min = '0, out_max = '0, out_data;
  logic out_valid, out_ready = 1'b1;

  int n_chk = 0, n_fail = 0;

  longint m_acc, m_held;
  bit m_hv, m_shi, m_slo;

  always #2.5 clk = ~clk;

  vloop_dual_pi dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_zc(smp_zc), .vref(vref), .err_thresh(err_thresh),
    .kp_slow(kp_slow), .ki_slow(ki_slow), .kp_fast(kp_fast), .ki_fast(ki_fast),
    .out_min(out_min), .out_max(out_max), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic longint clampv(input longint x);
    longint lo = longint'(out_min);
    longint hi = longint'(out_max);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  task automatic m_step(input longint v, input bit zc, output longint res);
    longint fb, einst, e, kp, ki, p, inc, s, u;
    bit fast, hold;
    if (zc) begin m_held = v; m_hv = 1; end
    fb    = m_hv ? m_held : v;
    einst = longint'(vref) - v;
    fast  = einst >= longint'(err_thresh);
    e     = fast ? einst : longint'(vref) - fb;
    kp    = fast ? longint'(kp_fast) : longint'(kp_slow);
    ki    = fast ? longint'(ki_fast) : longint'(ki_slow);
    p     = (kp * e) / (64'sd1 <<< FB);
    inc   = (ki * e) / (64'sd1 <<< FB);
    s     = m_acc + inc;
    hold  = (m_shi && inc > 0) || (m_slo && inc < 0);
    if (!hold) m_acc = clampv(s);
    u     = m_acc + p;
    m_shi = u >= longint'(out_max);
    m_slo = u <= longint'(out_min);
    res   = clampv(u);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; smp_zc = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(smp_ready == 1'b1, "R1 smp_ready in reset", longint'(smp_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    m_acc = 0; m_held = 0; m_hv = 0; m_shi = 0; m_slo = 0;
  endtask

  task automatic set_cfg(input int vr, input int th, input int kps, input int kis,
                         input int kpf, input int kif, input int lo, input int hi);
    vref = DW'(vr); err_thresh = DW'(th);
    kp_slow = DW'(kps); ki_slow = DW'(kis); kp_fast = DW'(kpf); ki_fast = DW'(kif);
    out_min = DW'(lo); out_max = DW'(hi);
  endtask

  task automatic send(input int v, input bit zc, input string rq);
    longint exp;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = DW'(v); smp_zc = zc;
    while (!smp_ready) @(negedge clk);
    m_step(longint'(v), zc, exp);
    @(negedge clk);
    smp_valid = 1'b0; smp_zc = 1'b0;
    chk(out_valid == 1'b1 && longint'(out_data) == exp, rq, longint'(out_data), exp);
  endtask

  // R1: reset state, then first update starts from a zero integrator
  task automatic t_reset();
    do_reset();
    set_cfg(1000, 200, 0, 4096, 0, 4096, -4000, 4000);
    send(990, 1'b0, "R1 first update from zero integrator");
  endtask

  // R3: no zero crossing yet, quiet mode uses live sample
  task automatic t_no_zc();
    do_reset();
    set_cfg(1000, 200, 4096, 0, 8192, 0, -4000, 4000);
    send(950, 1'b0, "R3 live feedback before first zc");
    send(1020, 1'b0, "R3 live feedback negative error");
  endtask

  // R2: marked beat latches and is used until next mark
  task automatic t_zc_hold();
    do_reset();
    set_cfg(1000, 200, 4096, 0, 8192, 0, -4000, 4000);
    send(900, 1'b1, "R2 marked beat uses own sample");
    send(990, 1'b0, "R2 held value used, not live");
    send(1100, 1'b0, "R2 held value with live overshoot");
    send(960, 1'b1, "R2 new mark replaces held value");
    send(1010, 1'b0, "R2 second held value used");
  endtask

  // R4: threshold boundary and gain pair choice
  task automatic t_mode();
    do_reset();
    set_cfg(1000, 200, 4096, 0, 8192, 0, -4000, 4000);
    send(1000, 1'b1, "R4 quiet at zero error");
    send(800, 1'b0, "R4 error equal threshold is recovery");
    send(801, 1'b0, "R4 error one below threshold is quiet");
    send(700, 1'b0, "R4 recovery with fast gains");
    send(1000, 1'b0, "R4 back to quiet");
  endtask

  // R5: integrator shared across modes
  task automatic t_shared();
    do_reset();
    set_cfg(1000, 200, 0, 2048, 0, 4096, -4000, 4000);
    send(990, 1'b0, "R5 quiet integral step");
    send(990, 1'b0, "R5 quiet integral accumulates");
    send(700, 1'b0, "R5 recovery continues same integrator");
    send(990, 1'b0, "R5 quiet resumes without step");
  endtask

  // R6 R7 R8: clamping and anti-windup
  task automatic t_sat();
    do_reset();
    set_cfg(1000, 2000, 8192, 4096, 0, 0, -100, 100);
    send(960, 1'b0, "R6 command clamps to upper limit");
    send(960, 1'b0, "R7 integrator frozen at limit");
    send(1010, 1'b0, "R7 reversal uses unwound integrator");
    set_cfg(0, 2000, 0, 4096, 0, 0, -100, 100);
    send(150, 1'b0, "R8 integrator clamps to lower limit");
    send(150, 1'b0, "R7 lower limit freeze");
    send(-30, 1'b0, "R8 recover from lower limit");
  endtask

  // R11: truncation toward zero
  task automatic t_round();
    do_reset();
    set_cfg(0, 2000, 6143, 0, 0, 0, -4000, 4000);
    send(3, 1'b0, "R11 negative P truncates toward zero");
    set_cfg(0, 2000, 0, 1365, 0, 0, -4000, 4000);
    send(3, 1'b0, "R11 negative I truncates to zero");
    set_cfg(0, 2000, 6143, 0, 0, 0, -4000, 4000);
    send(-3, 1'b0, "R11 positive P truncation");
  endtask

  // R9 R10: back-pressure
  task automatic t_backpressure();
    longint e1, e2;
    logic signed [DW-1:0] first;
    do_reset();
    set_cfg(1000, 200, 4096, 4096, 0, 0, -4000, 4000);
    @(negedge clk);
    out_ready = 1'b0;
    smp_valid = 1'b1; smp_data = DW'(990); smp_zc = 1'b0;
    m_step(990, 1'b0, e1);
    @(negedge clk);
    chk(out_valid == 1'b1 && longint'(out_data) == e1, "R9 result one cycle after accept",
        longint'(out_data), e1);
    first = out_data;
    smp_data = DW'(980);
    repeat (3) @(negedge clk);
    chk(smp_ready == 1'b0, "R10 smp_ready low while stalled", longint'(smp_ready), 0);
    chk(out_valid == 1'b1 && out_data == first, "R10 out_data held while stalled",
        longint'(out_data), longint'(first));
    out_ready = 1'b1;
    m_step(980, 1'b0, e2);
    @(negedge clk);
    smp_valid = 1'b0;
    chk(out_valid == 1'b1 && longint'(out_data) == e2, "R10 stalled sample used once",
        longint'(out_data), e2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 single beat per sample", longint'(out_valid), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_no_zc();
    t_zc_hold();
    t_mode();
    t_shared();
    t_sat();
    t_round();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule